// File: doc/BRIEF.md
# Dual Full-Date BCD Alarm with Power-Off Request

This block watches a live BCD calendar (seconds, minutes, hours, day, month, year) supplied by a separate counter. It holds two independent alarm sets. On every seconds-update strobe it compares both sets against the calendar, field by field. Because every field through the year takes part, an alarm fires only once within the century range.

The first set raises a status flag. That flag can drive the alarm interrupt and, if enabled, a wake request. The second set raises its own status flag and can also drive the alarm interrupt. When the power-control enable is set, the second set also pulls a power-enable pin to its off level. An external power manager reads that pin as a shutdown command, and the pin stays off until reset. A periodic timer flag sets on every strobe.

Software reaches all registers through a simple register bus. The bus takes byte writes on lane 0 or full 32-bit word writes, and read data is registered.

Top module: `dual_alarm_top`

## Requirements
- R1: When `tick_i` is high and all six time inputs equal the six alarm-1 fields, status bit 6 sets, whether or not any interrupt is enabled. A difference in any single field, the year included, leaves the bit clear.
- R2: The status register is at offset 0x44. Bit 2 is the timer flag, bit 6 is the alarm-1 flag and bit 7 is the alarm-2 flag. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. The timer flag sets on every `tick_i`.
- R3: Alarm-1 fields are at offsets 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34, and alarm-2 fields are at 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. Both sets hold, in that order, seconds, minutes, hours, day, month and year. Each field is written from `bus_wdata_i[7:0]` and reads back as written.
- R4: The interrupt-enable register is at 0x48. Bit 2 enables the timer, bit 3 enables alarm 1 and bit 4 enables alarm 2. `irq_timer_o` is status bit 2 AND enable bit 2. `irq_alarm_o` is (status bit 6 AND enable bit 3) OR (status bit 7 AND enable bit 4).
- R5: Enable bit 4 changes only on a word write (`bus_word_i`=1). A byte write updates bits 3:0 and leaves bit 4 unchanged.
- R6: `wake_o` is status bit 6 AND bit 1 of the wake-enable register at 0x7C.
- R7: The power-control register is at 0x98, and its bit 16 is written only by a word write. An alarm-2 match while bit 16 is set drives `pwr_en_o` low. An alarm-2 match while bit 16 is clear leaves `pwr_en_o` high.
- R8: Once `pwr_en_o` is low it stays low until reset. Clearing the status or the control bit does not raise it again.
- R9: After reset every register reads 0, `pwr_en_o` is 1 and all interrupt and wake outputs are 0.
- R10: Matching fields without `tick_i` set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle seconds-update strobe |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| day_i | input | 8 | Current day, BCD |
| mon_i | input | 8 | Current month, BCD |
| year_i | input | 8 | Current year, BCD |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe |
| bus_word_i | input | 1 | 1 = 32-bit word write, 0 = byte lane 0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the previous cycle's address |
| irq_timer_o | output | 1 | Periodic timer interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Wake request from alarm 1 |
| pwr_en_o | output | 1 | Power enable, low means off |

## Verification
The hardest condition to reach from the ports is the latched power-off. It needs an alarm-2 match that arrives after a word write of bit 16, and the pin must then stay low once both the cause and the control bit are removed. The stimulus first lets an alarm-2 match occur with the control bit clear, to show that the pin does not move. It then sets the control bit with a word write, replays the same calendar value, clears the status and the control bit, and checks that the pin is still low. Only a reset is expected to raise it.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int NFIELD   = 6;
  localparam int FW       = 8;
  localparam int AW       = 8;
  localparam int DW       = 32;
  localparam int NSET     = 2;
  localparam logic [AW-1:0] A1_BASE  = 8'h20;
  localparam logic [AW-1:0] A2_BASE  = 8'h80;
  localparam logic [AW-1:0] OFF_STAT = 8'h44;
  localparam logic [AW-1:0] OFF_IE   = 8'h48;
  localparam logic [AW-1:0] OFF_WAKE = 8'h7C;
  localparam logic [AW-1:0] OFF_PWR  = 8'h98;
  localparam int B_TMR  = 2;
  localparam int B_A1   = 6;
  localparam int B_A2   = 7;
  localparam int IE_TMR = 2;
  localparam int IE_A1  = 3;
  localparam int IE_A2  = 4;
  localparam int WK_A1  = 1;
  localparam int PC_EN  = 16;

  typedef struct packed {
    logic          we;
    logic          word;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } bus_wr_t;
endpackage

// File: rtl/alarm_set.sv
module alarm_set
  import dual_alarm_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int W  = FW,
  parameter logic [AW-1:0] BASE = 8'h20
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  bus_wr_t         wr_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic            tick_i,
  input  logic [NF*W-1:0] now_i,
  output logic            hit_o,
  output logic            rd_sel_o,
  output logic [W-1:0]    rd_val_o
);
  localparam int STRIDE = 4;

  logic [W-1:0] fld_q [NF];
  logic [NF-1:0] eq;
  logic [NF-1:0] rsel;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [AW-1:0] OFS = BASE + AW'(i * STRIDE);
    always_ff @(posedge clk_i) begin
      if (rst_i) fld_q[i] <= '0;
      else if (wr_i.we && wr_i.addr == OFS) fld_q[i] <= wr_i.wdata[W-1:0];
    end
    assign eq[i]   = (fld_q[i] == now_i[i*W +: W]);
    assign rsel[i] = (rd_addr_i == OFS);
  end

  assign hit_o    = tick_i && (&eq);
  assign rd_sel_o = |rsel;

  always_comb begin
    rd_val_o = '0;
    for (int i = 0; i < NF; i++)
      if (rsel[i]) rd_val_o = fld_q[i];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import dual_alarm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  input  bus_wr_t       wr_i,
  input  logic          tick_i,
  input  logic          hit1_i,
  input  logic          hit2_i,
  output logic [7:0]    stat_o,
  output logic [4:0]    ie_o,
  output logic [1:0]    wk_o,
  output logic          irq_timer_o,
  output logic          irq_alarm_o,
  output logic          wake_o
);
  logic [7:0] stat_q;
  logic [4:0] ie_q;
  logic [1:0] wk_q;
  logic       clr_hit;

  assign clr_hit = wr_i.we && wr_i.addr == OFF_STAT;

  always_ff @(posedge clk_i) begin
    if (rst_i) stat_q <= '0;
    else begin
      if (clr_hit) begin
        if (wr_i.wdata[B_TMR]) stat_q[B_TMR] <= 1'b0;
        if (wr_i.wdata[B_A1])  stat_q[B_A1]  <= 1'b0;
        if (wr_i.wdata[B_A2])  stat_q[B_A2]  <= 1'b0;
      end
      if (tick_i) stat_q[B_TMR] <= 1'b1;
      if (hit1_i) stat_q[B_A1]  <= 1'b1;
      if (hit2_i) stat_q[B_A2]  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ie_q <= '0;
    else if (wr_i.we && wr_i.addr == OFF_IE) begin
      ie_q[3:0] <= wr_i.wdata[3:0] & 4'b1100;
      if (wr_i.word) ie_q[IE_A2] <= wr_i.wdata[IE_A2];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) wk_q <= '0;
    else if (wr_i.we && wr_i.addr == OFF_WAKE) wk_q <= wr_i.wdata[1:0] & 2'b10;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_timer_o <= 1'b0;
      irq_alarm_o <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      irq_timer_o <= stat_q[B_TMR] & ie_q[IE_TMR];
      irq_alarm_o <= (stat_q[B_A1] & ie_q[IE_A1]) | (stat_q[B_A2] & ie_q[IE_A2]);
      wake_o      <= stat_q[B_A1] & wk_q[WK_A1];
    end
  end

  assign stat_o = stat_q & 8'hC4;
  assign ie_o   = ie_q;
  assign wk_o   = wk_q;

  // R1 / R2: a match recorded by the compare logic must show in status
  a_r1_hit_sets_status: assert property (@(posedge clk_i) disable iff (rst_i)
    hit1_i |=> stat_q[B_A1]);
  // R2: flag stays set unless a clearing write arrives
  a_r2_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_q[B_A1] && !clr_hit) |=> stat_q[B_A1]);
  // R6: wake only when wake enable was set
  a_r6_wake_gated: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |-> $past(wk_q[WK_A1]));
endmodule

// File: rtl/power_latch.sv
module power_latch
  import dual_alarm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  bus_wr_t wr_i,
  input  logic    hit2_i,
  output logic    ctl_o,
  output logic    pwr_en_o
);
  logic ctl_q;
  logic off_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) ctl_q <= 1'b0;
    else if (wr_i.we && wr_i.word && wr_i.addr == OFF_PWR) ctl_q <= wr_i.wdata[PC_EN];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) off_q <= 1'b0;
    else if (hit2_i && ctl_q) off_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) pwr_en_o <= 1'b1;
    else pwr_en_o <= ~off_q;
  end

  assign ctl_o = ctl_q;

  // R8: once off, stays off until reset
  a_r8_off_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    !pwr_en_o |=> !pwr_en_o);
endmodule

// File: rtl/dual_alarm_top.sv
module dual_alarm_top
  import dual_alarm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic [7:0]    sec_i,
  input  logic [7:0]    min_i,
  input  logic [7:0]    hour_i,
  input  logic [7:0]    day_i,
  input  logic [7:0]    mon_i,
  input  logic [7:0]    year_i,
  input  logic [7:0]    bus_addr_i,
  input  logic          bus_we_i,
  input  logic          bus_word_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          irq_timer_o,
  output logic          irq_alarm_o,
  output logic          wake_o,
  output logic          pwr_en_o
);
  bus_wr_t wr;
  logic [NFIELD*FW-1:0] now;
  logic [NSET-1:0]      hit;
  logic [NSET-1:0]      rsel;
  logic [FW-1:0]        rval [NSET];
  logic [7:0]           stat;
  logic [4:0]           ie;
  logic [1:0]           wk;
  logic                 ctl;
  logic [DW-1:0]        rd_d;

  assign wr  = '{we: bus_we_i, word: bus_word_i, addr: bus_addr_i, wdata: bus_wdata_i};
  assign now = {year_i, mon_i, day_i, hour_i, min_i, sec_i};

  for (genvar s = 0; s < NSET; s++) begin : g_set
    localparam logic [AW-1:0] SB = (s == 0) ? A1_BASE : A2_BASE;
    alarm_set #(.NF(NFIELD), .W(FW), .BASE(SB)) u_set (
      .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr), .rd_addr_i(bus_addr_i),
      .tick_i(tick_i), .now_i(now), .hit_o(hit[s]),
      .rd_sel_o(rsel[s]), .rd_val_o(rval[s]));
  end

  irq_ctrl u_irq (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr), .tick_i(tick_i),
    .hit1_i(hit[0]), .hit2_i(hit[1]), .stat_o(stat), .ie_o(ie), .wk_o(wk),
    .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o), .wake_o(wake_o));

  power_latch u_pwr (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr), .hit2_i(hit[1]),
    .ctl_o(ctl), .pwr_en_o(pwr_en_o));

  always_comb begin
    rd_d = '0;
    if (rsel[0]) rd_d[FW-1:0] = rval[0];
    else if (rsel[1]) rd_d[FW-1:0] = rval[1];
    else begin
      case (bus_addr_i)
        OFF_STAT: rd_d[7:0]   = stat;
        OFF_IE:   rd_d[4:0]   = ie;
        OFF_WAKE: rd_d[1:0]   = wk;
        OFF_PWR:  rd_d[PC_EN] = ctl;
        default:  rd_d        = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) bus_rdata_o <= '0;
    else bus_rdata_o <= rd_d;
  end

  // R4: alarm interrupt requires an enabled source in the prior cycle
  a_r4_alarm_enabled: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_alarm_o |-> $past(ie[IE_A1] | ie[IE_A2]));
  // R7: power pin falls only when control enable was set
  a_r7_off_needs_ctl: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pwr_en_o) |-> $past(ctl, 2));
  // R10: no alarm flag rises without a strobe
  a_r10_tick_only: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(stat[B_A1]) |-> $past(tick_i));
endmodule

// File: tb/sim_dual_alarm_top.sv
module sim_dual_alarm_top;
  logic        clk = 0, rst = 1, tick = 0;
  logic [7:0]  sec = 0, min = 0, hour = 0, day = 0, mon = 0, year = 0;
  logic [7:0]  addr = 0;
  logic        we = 0, word = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq_t, irq_a, wake, pwr;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  dual_alarm_top u0 (.clk_i(clk), .rst_i(rst), .tick_i(tick), .sec_i(sec),
    .min_i(min), .hour_i(hour), .day_i(day), .mon_i(mon), .year_i(year),
    .bus_addr_i(addr), .bus_we_i(we), .bus_word_i(word), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_timer_o(irq_t), .irq_alarm_o(irq_a),
    .wake_o(wake), .pwr_en_o(pwr));

  // time {year,mon,day,hour,min,sec}, expected status bits 7..6
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {48'h99_12_31_23_59_58, 2'b01},
    {48'h98_12_31_23_59_58, 2'b00},
    {48'h99_11_31_23_59_58, 2'b00},
    {48'h99_12_30_23_59_58, 2'b00},
    {48'h99_12_31_22_59_58, 2'b00},
    {48'h99_12_31_23_58_58, 2'b00},
    {48'h99_12_31_23_59_59, 2'b00},
    {48'h00_01_01_00_00_05, 2'b10},
    {48'h00_01_01_00_00_06, 2'b00},
    {48'h01_01_01_00_00_05, 2'b00}
  };

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic w);
    @(negedge clk); addr = a; wdata = d; word = w; we = 1;
    @(negedge clk); we = 0; word = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic set_time(logic [47:0] t);
    {year, mon, day, hour, min, sec} = t;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk); rst = 0;
    // R9 reset state
    rd(8'h44, d); chk("R9 status", d, 0);
    rd(8'h80, d); chk("R9 a2 sec", d, 0);
    chk("R9 pwr", {28'd0, pwr, irq_t, irq_a, wake}, 32'h8);
    // R3 program alarms (sec..year)
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a1v, a2v;
      a1v = 8'(48'h99_12_31_23_59_58 >> (8*i));
      a2v = 8'(48'h00_01_01_00_00_05 >> (8*i));
      wr(8'h20 + 8'(4*i), {24'd0, a1v}, 0);
      wr(8'h80 + 8'(4*i), {24'hABCDEF, a2v}, 1);
    end
    for (int i = 0; i < 6; i++) begin
      rd(8'h80 + 8'(4*i), d);
      chk("R3 a2 readback", d, {24'd0, 8'(48'h00_01_01_00_00_05 >> (8*i))});
      rd(8'h20 + 8'(4*i), d);
      chk("R3 a1 readback", d, {24'd0, 8'(48'h99_12_31_23_59_58 >> (8*i))});
    end
    // R10 match without tick
    set_time(48'h99_12_31_23_59_58);
    repeat (3) @(negedge clk);
    rd(8'h44, d); chk("R10 no tick", d, 0);
    // R1/R2/R7 vector walk, no enables, ctl clear
    for (int v = 0; v < NV; v++) begin
      set_time(VEC[v][49:2]);
      pulse();
      rd(8'h44, d);
      chk("R1 vector status", d, {24'd0, VEC[v][1:0], 6'b000100});
      chk("R7 pwr stays on", {31'd0, pwr}, 1);
      wr(8'h44, 32'hC4, 0);
    end
    // R2 write 0 keeps flag, write 1 clears
    set_time(48'h99_12_31_23_59_58); pulse();
    wr(8'h44, 32'h00, 0);
    rd(8'h44, d); chk("R2 zero write keeps", d, 32'h44);
    wr(8'h44, 32'h40, 0);
    rd(8'h44, d); chk("R2 w1c alarm1", d, 32'h04);
    wr(8'h44, 32'h04, 0);
    rd(8'h44, d); chk("R2 w1c timer", d, 32'h00);
    // R5 byte write cannot set bit 4
    wr(8'h48, 32'h1C, 0);
    rd(8'h48, d); chk("R5 byte ie", d, 32'h0C);
    wr(8'h48, 32'h1C, 1);
    rd(8'h48, d); chk("R5 word ie", d, 32'h1C);
    wr(8'h48, 32'h00, 0);
    rd(8'h48, d); chk("R5 byte keeps bit4", d, 32'h10);
    // R4 interrupt gating
    wr(8'h48, 32'h08, 1);
    set_time(48'h99_12_31_23_59_58); pulse();
    chk("R4 irq alarm1 timer off", {30'd0, irq_a, irq_t}, 32'h2);
    wr(8'h48, 32'h04, 1);
    @(negedge clk); @(negedge clk);
    chk("R4 irq timer only", {30'd0, irq_a, irq_t}, 32'h1);
    // R6 wake
    chk("R6 wake off", {31'd0, wake}, 0);
    wr(8'h7C, 32'h02, 0);
    @(negedge clk); @(negedge clk);
    chk("R6 wake on", {31'd0, wake}, 1);
    wr(8'h44, 32'hC4, 0);
    @(negedge clk); @(negedge clk);
    chk("R6 wake cleared", {29'd0, wake, irq_a, irq_t}, 0);
    // R4 alarm2 via bit4
    wr(8'h48, 32'h10, 1);
    set_time(48'h00_01_01_00_00_05); pulse();
    chk("R4 irq alarm2", {31'd0, irq_a}, 1);
    wr(8'h44, 32'hC4, 0);
    // R7 byte write cannot set ctl; then word write does
    wr(8'h98, 32'h0001_0000, 0);
    rd(8'h98, d); chk("R7 byte ctl", d, 0);
    wr(8'h98, 32'h0001_0000, 1);
    rd(8'h98, d); chk("R7 word ctl", d, 32'h0001_0000);
    pulse();
    chk("R7 pwr off", {31'd0, pwr}, 0);
    // R8 sticky
    wr(8'h44, 32'hC4, 0);
    wr(8'h98, 32'h0, 1);
    set_time(48'h11_11_11_11_11_11); pulse();
    repeat (4) @(negedge clk);
    chk("R8 pwr sticky", {31'd0, pwr}, 0);
    // R9 reset restores
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R9 pwr after reset", {28'd0, pwr, irq_t, irq_a, wake}, 32'h8);
    rd(8'h98, d); chk("R9 ctl after reset", d, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule